// File: doc/BRIEF.md
# Packed Attribute Vector Unpacker

This block receives a stream of 32-bit configuration words in which each group of three consecutive words carries four 24-bit floating-point values. Once the third word of a group arrives, it splits the 96 bits into a four-component vector and passes each 24-bit value through unchanged. The block does no arithmetic on the values.

A programmable target index decides where each finished vector goes. Indices 0 to 14 name entries of a default-attribute table; after each table write the index steps forward by one. Index 15 switches the block into an immediate vertex stream. In that stream, vectors fill successive attribute slots of a vertex buffer. When the slot that matches a programmed maximum is filled, the block raises a one-cycle vertex-complete strobe. Writing the index register restarts the word group and the slot count, and raises a request for the downstream pipeline to reconfigure. That request clears when the next complete immediate vertex is emitted.

Top module: `packed_attr_unpacker`

## Requirements
- R1: Each vector is emitted one cycle after the edge that accepts the third data word of a group. After that word the group counter returns to zero, and the first and second words of a group produce no output strobe.
- R2: Component w of the emitted vector is bits 31:8 of the first word of the group.
- R3: Component z is the low 8 bits of the first word, followed by (in the less significant position) the upper 16 bits of the second word.
- R4: Component y is the low 16 bits of the second word followed by the upper 8 bits of the third word. Component x is the low 24 bits of the third word.
- R5: When the target index is below 15, the vector is written to the table entry at that index (tableWe with tableAddr = index), and the index then increases by one.
- R6: When the target index equals 15, the vector is written to the immediate slot named by the slot counter (immWe with immSlot), and the table is not written.
- R7: In immediate mode the slot counter increments after each vector. When it equals or exceeds maxAttr, it wraps to zero, and vertexDone pulses together with immWe for that vector.
- R8: When the target index is 16 or more, the vector is discarded: dropErr pulses, neither tableWe nor immWe is raised, and the index is left unchanged.
- R9: An index-register write sets the index, clears the slot counter and the word-group counter, and sets pipeResetReq. A data word presented in the same cycle is ignored.
- R10: pipeResetReq is low after reset and falls in the same cycle that vertexDone is raised.
- R11: After reset all strobes are low and the index, the word-group counter and the slot counter are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| idxWrite | input | 1 | Write strobe for the target index register |
| idxValue | input | 5 | New target index |
| wordValid | input | 1 | Data word strobe |
| wordData | input | 32 | Packed data word |
| maxAttr | input | 4 | Highest immediate attribute slot of a vertex |
| attrX | output | 24 | Unpacked x component |
| attrY | output | 24 | Unpacked y component |
| attrZ | output | 24 | Unpacked z component |
| attrW | output | 24 | Unpacked w component |
| tableWe | output | 1 | Default-table write strobe |
| tableAddr | output | 4 | Default-table entry |
| immWe | output | 1 | Immediate buffer write strobe |
| immSlot | output | 4 | Immediate buffer slot |
| vertexDone | output | 1 | Last attribute of an immediate vertex |
| dropErr | output | 1 | Vector discarded, index out of range |
| pipeResetReq | output | 1 | Pipeline reconfiguration request |

## Verification
The assertions check several rules on every cycle. The word-group counter stays within three positions, and at most one of the table, immediate and drop strobes is high at a time. An index write always leaves both counters cleared with the reset request set. vertexDone only appears with an immediate write and with the request already lowered. The bench scenarios show the rest: the exact bit placement of each component across the three words, the index stepping from 14 into immediate mode, slot wrapping at several maxAttr values including zero, and a group restarted part-way by an index write.

// File: rtl/attr_unpack_pkg.sv
package attr_unpack_pkg;
  localparam int WORD_W = 32;
  localparam int COMP_W = 24;
  localparam int WORDS_PER_VEC = 3;
  localparam int IDX_W = 5;
  localparam int SLOT_W = 4;
  localparam int IMM_INDEX = 15;
  localparam int CNT_W = $clog2(WORDS_PER_VEC);
  localparam int HOLD_N = WORDS_PER_VEC - 1;

  typedef enum logic [1:0] {
    DEST_TABLE = 2'd0,
    DEST_IMM   = 2'd1,
    DEST_DROP  = 2'd2
  } destKind_e;

  typedef struct packed {
    logic              take;
    logic [CNT_W-1:0]  pos;
    logic              emit;
    destKind_e         dest;
    logic [SLOT_W-1:0] addr;
    logic              last;
  } ctrlStrobe_t;

  typedef struct packed {
    logic [COMP_W-1:0] w;
    logic [COMP_W-1:0] z;
    logic [COMP_W-1:0] y;
    logic [COMP_W-1:0] x;
  } attrVec_t;
endpackage

// File: rtl/attr_unpack_ctrl.sv
module attr_unpack_ctrl
  import attr_unpack_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              idxWrite,
  input  logic [IDX_W-1:0]  idxValue,
  input  logic              wordValid,
  input  logic [SLOT_W-1:0] maxAttr,
  output ctrlStrobe_t       strb,
  output logic              pipeResetReq
);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(WORDS_PER_VEC - 1);
  localparam logic [IDX_W-1:0] IMM_IDX = IDX_W'(IMM_INDEX);

  logic [CNT_W-1:0]  wordCnt;
  logic [IDX_W-1:0]  targetIdx;
  logic [SLOT_W-1:0] slotCnt;
  logic              resetReq;

  always_comb begin
    strb.take = wordValid && !idxWrite;
    strb.pos  = wordCnt;
    strb.emit = strb.take && (wordCnt == LAST_POS);
    if (targetIdx < IMM_IDX) begin
      strb.dest = DEST_TABLE;
      strb.addr = targetIdx[SLOT_W-1:0];
    end else if (targetIdx == IMM_IDX) begin
      strb.dest = DEST_IMM;
      strb.addr = slotCnt;
    end else begin
      strb.dest = DEST_DROP;
      strb.addr = '0;
    end
    strb.last = (strb.dest == DEST_IMM) && (slotCnt >= maxAttr);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordCnt   <= '0;
      targetIdx <= '0;
      slotCnt   <= '0;
      resetReq  <= 1'b0;
    end else if (idxWrite) begin
      targetIdx <= idxValue;
      wordCnt   <= '0;
      slotCnt   <= '0;
      resetReq  <= 1'b1;
    end else if (strb.take) begin
      wordCnt <= strb.emit ? '0 : wordCnt + 1'b1;
      if (strb.emit) begin
        case (strb.dest)
          DEST_TABLE: targetIdx <= targetIdx + 1'b1;
          DEST_IMM: begin
            if (strb.last) begin
              slotCnt  <= '0;
              resetReq <= 1'b0;
            end else begin
              slotCnt <= slotCnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign pipeResetReq = resetReq;

  assert_group_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    wordCnt <= LAST_POS);

  assert_index_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    idxWrite |=> (wordCnt == '0 && slotCnt == '0 && resetReq));

  assert_table_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.emit && strb.dest == DEST_TABLE) |=> (targetIdx == $past(targetIdx) + 1'b1));

  assert_drop_keeps_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.emit && strb.dest == DEST_DROP) |=> $stable(targetIdx));
endmodule

// File: rtl/attr_unpack_datapath.sv
module attr_unpack_datapath
  import attr_unpack_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [WORD_W-1:0] wordData,
  input  logic              pipeResetReq,
  output attrVec_t          vecOut,
  output logic              tableWe,
  output logic [SLOT_W-1:0] tableAddr,
  output logic              immWe,
  output logic [SLOT_W-1:0] immSlot,
  output logic              vertexDone,
  output logic              dropErr
);
  logic [WORD_W-1:0] holdWord [HOLD_N];
  attrVec_t          unpacked;

  for (genvar g = 0; g < HOLD_N; g++) begin : gHold
    always_ff @(posedge clk) begin
      if (!rstN) holdWord[g] <= '0;
      else if (strb.take && strb.pos == CNT_W'(g)) holdWord[g] <= wordData;
    end
  end

  always_comb begin
    unpacked.w = holdWord[0][31:8];
    unpacked.z = {holdWord[0][7:0], holdWord[1][31:16]};
    unpacked.y = {holdWord[1][15:0], wordData[31:24]};
    unpacked.x = wordData[23:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecOut     <= '0;
      tableWe    <= 1'b0;
      tableAddr  <= '0;
      immWe      <= 1'b0;
      immSlot    <= '0;
      vertexDone <= 1'b0;
      dropErr    <= 1'b0;
    end else begin
      tableWe    <= strb.emit && strb.dest == DEST_TABLE;
      immWe      <= strb.emit && strb.dest == DEST_IMM;
      dropErr    <= strb.emit && strb.dest == DEST_DROP;
      vertexDone <= strb.emit && strb.last;
      if (strb.emit) begin
        vecOut    <= unpacked;
        tableAddr <= strb.addr;
        immSlot   <= strb.addr;
      end
    end
  end

  assert_one_dest_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({tableWe, immWe, dropErr}));

  assert_done_with_imm_R7: assert property (@(posedge clk) disable iff (!rstN)
    vertexDone |-> immWe);

  assert_req_low_on_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    vertexDone |-> !pipeResetReq);

  assert_table_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    tableWe |-> (tableAddr < SLOT_W'(IMM_INDEX)));
endmodule

// File: rtl/packed_attr_unpacker.sv
module packed_attr_unpacker
  import attr_unpack_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              idxWrite,
  input  logic [IDX_W-1:0]  idxValue,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordData,
  input  logic [SLOT_W-1:0] maxAttr,
  output logic [COMP_W-1:0] attrX,
  output logic [COMP_W-1:0] attrY,
  output logic [COMP_W-1:0] attrZ,
  output logic [COMP_W-1:0] attrW,
  output logic              tableWe,
  output logic [SLOT_W-1:0] tableAddr,
  output logic              immWe,
  output logic [SLOT_W-1:0] immSlot,
  output logic              vertexDone,
  output logic              dropErr,
  output logic              pipeResetReq
);
  ctrlStrobe_t strb;
  attrVec_t    vecOut;

  attr_unpack_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .idxWrite(idxWrite), .idxValue(idxValue),
    .wordValid(wordValid), .maxAttr(maxAttr), .strb(strb),
    .pipeResetReq(pipeResetReq)
  );

  attr_unpack_datapath uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wordData(wordData),
    .pipeResetReq(pipeResetReq), .vecOut(vecOut), .tableWe(tableWe),
    .tableAddr(tableAddr), .immWe(immWe), .immSlot(immSlot),
    .vertexDone(vertexDone), .dropErr(dropErr)
  );

  assign attrX = vecOut.x;
  assign attrY = vecOut.y;
  assign attrZ = vecOut.z;
  assign attrW = vecOut.w;
endmodule

// File: tb/sim_packed_attr_unpacker.sv
module sim_packed_attr_unpacker;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic idxWrite = 1'b0;
  logic [4:0] idxValue = '0;
  logic wordValid = 1'b0;
  logic [31:0] wordData = '0;
  logic [3:0] maxAttr = '0;
  logic [23:0] attrX, attrY, attrZ, attrW;
  logic tableWe, immWe, vertexDone, dropErr, pipeResetReq;
  logic [3:0] tableAddr, immSlot;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int mIdx = 0, mSlot = 0, mWord = 0;
  bit mReq = 0;
  logic [31:0] mBuf [3];

  always #10 clk = ~clk;

  packed_attr_unpacker u0 (
    .clk(clk), .rstN(rstN), .idxWrite(idxWrite), .idxValue(idxValue),
    .wordValid(wordValid), .wordData(wordData), .maxAttr(maxAttr),
    .attrX(attrX), .attrY(attrY), .attrZ(attrZ), .attrW(attrW),
    .tableWe(tableWe), .tableAddr(tableAddr), .immWe(immWe), .immSlot(immSlot),
    .vertexDone(vertexDone), .dropErr(dropErr), .pipeResetReq(pipeResetReq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [95:0] expVec(input logic [31:0] a, input logic [31:0] b,
                                        input logic [31:0] c);
    // order: w, z, y, x
    return {a[31:8], a[7:0], b[31:16], b[15:0], c[31:24], c[23:0]};
  endfunction

  task automatic writeIdx(input logic [4:0] v);
    @(negedge clk);
    idxWrite = 1'b1; idxValue = v;
    @(posedge clk);
    @(negedge clk);
    idxWrite = 1'b0;
    mIdx = v; mSlot = 0; mWord = 0; mReq = 1;
    chk("R9 req set", pipeResetReq, 1);
    chk("R9 no strobe", {tableWe, immWe, dropErr}, 0);
  endtask

  task automatic writeWord(input logic [31:0] w);
    logic [95:0] ev;
    @(negedge clk);
    wordValid = 1'b1; wordData = w;
    @(posedge clk);
    @(negedge clk);
    wordValid = 1'b0;
    mBuf[mWord] = w;
    if (mWord < 2) begin
      mWord++;
      chk("R1 no early strobe", {tableWe, immWe, dropErr, vertexDone}, 0);
    end else begin
      mWord = 0;
      ev = expVec(mBuf[0], mBuf[1], mBuf[2]);
      if (mIdx < 15) begin
        chk("R5 tableWe", {tableWe, immWe, dropErr}, 3'b100);
        chk("R5 tableAddr", tableAddr, mIdx[3:0]);
        chk("R2 R3 R4 vector", {attrW, attrZ, attrY, attrX}, ev);
        mIdx++;
      end else if (mIdx == 15) begin
        chk("R6 immWe", {tableWe, immWe, dropErr}, 3'b010);
        chk("R6 immSlot", immSlot, mSlot[3:0]);
        chk("R2 R3 R4 vector", {attrW, attrZ, attrY, attrX}, ev);
        if (mSlot >= int'(maxAttr)) begin
          chk("R7 vertexDone", vertexDone, 1);
          mSlot = 0; mReq = 0;
        end else begin
          chk("R7 no vertexDone", vertexDone, 0);
          mSlot++;
        end
      end else begin
        chk("R8 dropErr", {tableWe, immWe, dropErr}, 3'b001);
      end
    end
    chk("R10 pipeResetReq", pipeResetReq, mReq);
  endtask

  task automatic sendVec(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    writeWord(a); writeWord(b); writeWord(c);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 reset strobes", {tableWe, immWe, dropErr, vertexDone, pipeResetReq}, 0);

    // R2 R3 R4 directed bit placement, table entry 0
    sendVec(32'hAABBCCDD, 32'h11223344, 32'h55667788);
    chk("R2 w", attrW, 24'hAABBCC);
    chk("R3 z", attrZ, 24'hDD1122);
    chk("R4 y", attrY, 24'h334455);
    chk("R4 x", attrX, 24'h667788);

    // R5 fill remaining table entries up to 14, stepping into immediate mode
    for (int i = 1; i < 15; i++) sendVec($urandom, $urandom, $urandom);

    // R6 R7 immediate mode with maxAttr 2
    maxAttr = 4'd2;
    writeIdx(5'd15);
    for (int i = 0; i < 6; i++) sendVec($urandom, $urandom, $urandom);

    // R9 index write mid-group restarts the group
    writeIdx(5'd3);
    writeWord(32'hDEADBEEF);
    writeWord(32'hCAFEF00D);
    writeIdx(5'd4);
    sendVec(32'h01234567, 32'h89ABCDEF, 32'h0F1E2D3C);

    // R9 data word with simultaneous index write is ignored
    @(negedge clk);
    idxWrite = 1'b1; idxValue = 5'd15; wordValid = 1'b1; wordData = 32'hFFFFFFFF;
    @(posedge clk);
    @(negedge clk);
    idxWrite = 1'b0; wordValid = 1'b0;
    mIdx = 15; mSlot = 0; mWord = 0; mReq = 1;
    chk("R9 same-cycle word ignored", {tableWe, immWe, dropErr}, 0);
    // R7 maxAttr 0: every vector completes a vertex
    maxAttr = 4'd0;
    sendVec($urandom, $urandom, $urandom);
    sendVec($urandom, $urandom, $urandom);

    // R8 out-of-range index, index unchanged
    writeIdx(5'd16);
    sendVec($urandom, $urandom, $urandom);
    sendVec($urandom, $urandom, $urandom);
    writeIdx(5'd31);
    sendVec($urandom, $urandom, $urandom);

    // random mix
    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(0, 9) == 0) begin
        maxAttr = 4'($urandom_range(0, 5));
        writeIdx(5'($urandom_range(10, 17)));
      end else begin
        writeWord($urandom);
      end
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule